// File: doc/BRIEF.md
# Self-Correcting Token Ring Sequencer

This block steps a single token through a ring of sixteen flip-flops, one position per clock on which the advance input is high. It is meant as a compact sequencer for control logic that must not lock up. If an upset, a glitch or a bad load leaves the ring with no token or with several tokens, the block returns to a legal single-token state by itself, with no external reset.

A combinational checker watches the ring at all times. It splits the vector into four-bit groups. Each group reports two facts: whether it holds no set bit, and whether it holds exactly one. A second tier then combines those pairs, so that zero, one and many set bits are always told apart.

One of two recovery schemes is chosen at build time by a parameter:
- **Ripple mode** lets surplus tokens drain out of the top stage. A fresh token enters the bottom stage only when the lower fifteen stages are empty.
- **Restart mode** reloads the start value whenever an advance finds the terminal stage set or the ring empty.

A load port lets a test, or a higher-level controller, force an arbitrary vector into the ring.

Top module: `token_ring_seq`

## Requirements
- R1: A synchronous reset (`rst` high at a clock edge) loads `stateVec` = 16'h0001, that is, bit 0 set. Reset takes priority over load and advance.
- R2: With a legal state, an edge with `advance` high moves the token from bit i to bit i+1. A token in bit 15 moves to bit 0.
- R3: `illegal` is combinational from `stateVec` and is 1 exactly when the number of set bits is not one. This includes all-zero and 16'b1111_1110_1100_0001.
- R4: `wrapPulse` is 1 exactly when `advance` is high and bit 15 of `stateVec` is set.
- R5: In ripple mode (MODE = RECOVER_RIPPLE) an advance always shifts bits 0..14 up one place and drops the old bit 15. The new bit 0 is 1 only when bits 0..14 were all zero, so an all-zero ring becomes 16'h0001 after one advance.
- R6: In restart mode (MODE = RECOVER_RESTART) an advance rotates the ring. When bit 15 is set or the ring is all zero, the advance instead loads 16'h0001, which clears any stray bits.
- R7: From any state, in either mode, `stateVec` holds exactly one set bit after at most 16 advancing edges, with no reset or load in between.
- R8: `loadEn` high at an edge (without reset) writes `loadVal` into `stateVec`, taking priority over `advance`.
- R9: With `advance`, `loadEn` and `rst` low, `stateVec` holds its value, and `illegal` keeps describing the held vector.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset to the start state |
| advance | input | 1 | Step the ring on this edge |
| loadEn | input | 1 | Force `loadVal` into the ring on this edge |
| loadVal | input | 16 | Vector written by the load port |
| stateVec | output | 16 | Current ring contents, bit 0 is the first stage |
| wrapPulse | output | 1 | Advance while the terminal stage holds a token |
| illegal | output | 1 | Ring holds other than exactly one set bit |

## Verification
The properties assume that `rst` is high on the first sampled edge and that every input is a known value after that. They also assume that `loadEn` is the only way a corrupted vector enters the ring, which is why the recovery bound restarts its count whenever a load occurs. The stimulus drives inputs one time unit after each rising edge and starts every corruption through the load port. It then leaves `loadEn` low for the whole recovery window while `advance` stays high.

// File: rtl/token_ring_pkg.sv
package token_ring_pkg;

  // Build-time choice of how a corrupted ring heals itself.
  typedef enum logic {
    RECOVER_RIPPLE  = 1'b0,
    RECOVER_RESTART = 1'b1
  } recoverMode_e;

  // Strobes passed from the control to the datapath.
  typedef struct packed {
    logic loadNow;
    logic shiftNow;
    logic restartNow;
    logic insertBit;
  } ringStrobe_t;

endpackage

// File: rtl/hot_group_check.sv
// Two-tier detector for "exactly one bit set".
// Each group reports both an empty flag and a single flag.
module hot_group_check #(
  parameter int STAGES  = 16,
  parameter int GROUP_W = 4
) (
  input  logic [STAGES-1:0] vec,
  output logic              illegal
);
  localparam int GROUPS = STAGES / GROUP_W;

  logic [GROUPS-1:0] groupNone;
  logic [GROUPS-1:0] groupOne;

  for (genvar g = 0; g < GROUPS; g++) begin : gGroup
    logic [GROUP_W-1:0] slice;
    assign slice        = vec[g*GROUP_W +: GROUP_W];
    assign groupNone[g] = ~|slice;
    assign groupOne[g]  = (|slice) && ((slice & (slice - GROUP_W'(1))) == '0);
  end

  logic oneGroupSingle;
  logic noCrowdedGroup;

  assign oneGroupSingle = (|groupOne) && ((groupOne & (groupOne - GROUPS'(1))) == '0);
  assign noCrowdedGroup = &(groupNone | groupOne);
  assign illegal        = ~(oneGroupSingle & noCrowdedGroup);
endmodule

// File: rtl/ring_ctrl.sv
// Control: decides load, shift, restart and the bit shifted into stage 0.
module ring_ctrl
  import token_ring_pkg::*;
#(
  parameter int           STAGES = 16,
  parameter recoverMode_e MODE   = RECOVER_RIPPLE
) (
  input  logic              advance,
  input  logic              loadEn,
  input  logic [STAGES-1:0] stateVec,
  output ringStrobe_t       strobe,
  output logic              wrapPulse
);
  logic lowEmpty;
  logic lastHot;
  logic ringEmpty;

  assign lowEmpty  = ~|stateVec[STAGES-2:0];
  assign lastHot   = stateVec[STAGES-1];
  assign ringEmpty = lowEmpty & ~lastHot;
  assign wrapPulse = advance & lastHot;

  assign strobe.loadNow  = loadEn;
  assign strobe.shiftNow = advance & ~loadEn;

  if (MODE == RECOVER_RIPPLE) begin : gRipple
    // Stage 0 takes a token only when every lower stage is empty.
    assign strobe.insertBit  = lowEmpty;
    assign strobe.restartNow = 1'b0;
  end else begin : gRestart
    // Plain rotation, with a return to the start state on wrap or on an empty ring.
    assign strobe.insertBit  = lastHot;
    assign strobe.restartNow = advance & ~loadEn & (lastHot | ringEmpty);
  end
endmodule

// File: rtl/ring_path.sv
// Datapath: the ring register and its next-state selection.
module ring_path
  import token_ring_pkg::*;
#(
  parameter int STAGES = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  ringStrobe_t       strobe,
  input  logic [STAGES-1:0] loadVal,
  output logic [STAGES-1:0] stateVec
);
  localparam logic [STAGES-1:0] START = STAGES'(1);

  always_ff @(posedge clk) begin
    if (rst)                    stateVec <= START;
    else if (strobe.loadNow)    stateVec <= loadVal;
    else if (strobe.restartNow) stateVec <= START;
    else if (strobe.shiftNow)   stateVec <= {stateVec[STAGES-2:0], strobe.insertBit};
  end
endmodule

// File: rtl/token_ring_seq.sv
// Top: the ring sequencer with its legality checker.
module token_ring_seq
  import token_ring_pkg::*;
#(
  parameter int           STAGES  = 16,
  parameter int           GROUP_W = 4,
  parameter recoverMode_e MODE    = RECOVER_RIPPLE
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              advance,
  input  logic              loadEn,
  input  logic [STAGES-1:0] loadVal,
  output logic [STAGES-1:0] stateVec,
  output logic              wrapPulse,
  output logic              illegal
);
  ringStrobe_t strobe;

  ring_ctrl #(.STAGES(STAGES), .MODE(MODE)) uCtrl (
    .advance  (advance),
    .loadEn   (loadEn),
    .stateVec (stateVec),
    .strobe   (strobe),
    .wrapPulse(wrapPulse)
  );

  ring_path #(.STAGES(STAGES)) uPath (
    .clk     (clk),
    .rst     (rst),
    .strobe  (strobe),
    .loadVal (loadVal),
    .stateVec(stateVec)
  );

  hot_group_check #(.STAGES(STAGES), .GROUP_W(GROUP_W)) uCheck (
    .vec    (stateVec),
    .illegal(illegal)
  );
endmodule

// File: rtl/token_ring_sva.sv
module token_ring_sva
  import token_ring_pkg::*;
#(
  parameter int           STAGES = 16,
  parameter recoverMode_e MODE   = RECOVER_RIPPLE
) (
  input logic              clk,
  input logic              rst,
  input logic              advance,
  input logic              loadEn,
  input logic [STAGES-1:0] loadVal,
  input logic [STAGES-1:0] stateVec,
  input logic              wrapPulse,
  input logic              illegal
);
  localparam int CW = $clog2(STAGES) + 2;

  // Counts advancing edges taken while the ring stays illegal.
  logic [CW-1:0] badAdv;
  always_ff @(posedge clk) begin
    if (rst || loadEn || !illegal) badAdv <= '0;
    else if (advance)              badAdv <= badAdv + CW'(1);
  end

  assert_reset_start_R1: assert property (@(posedge clk)
    rst |=> stateVec == STAGES'(1));

  assert_rotate_R2: assert property (@(posedge clk) disable iff (rst)
    (advance && !loadEn && !illegal) |=>
      stateVec == {$past(stateVec[STAGES-2:0]), $past(stateVec[STAGES-1])});

  assert_flag_count_R3: assert property (@(posedge clk) disable iff (rst)
    illegal == ($countones(stateVec) != 1));

  assert_wrap_restart_R4: assert property (@(posedge clk) disable iff (rst)
    (wrapPulse && !loadEn && !illegal) |=> stateVec == STAGES'(1));

  assert_recover_bound_R7: assert property (@(posedge clk) disable iff (rst)
    badAdv <= CW'(STAGES));

  assert_load_R8: assert property (@(posedge clk) disable iff (rst)
    loadEn |=> stateVec == $past(loadVal));

  assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (!advance && !loadEn) |=> $stable(stateVec));
endmodule

bind token_ring_seq token_ring_sva #(.STAGES(STAGES), .MODE(MODE)) uSva (
  .clk      (clk),
  .rst      (rst),
  .advance  (advance),
  .loadEn   (loadEn),
  .loadVal  (loadVal),
  .stateVec (stateVec),
  .wrapPulse(wrapPulse),
  .illegal  (illegal)
);

// File: tb/tb_token_ring_seq.sv
module tb_token_ring_seq;
  import token_ring_pkg::*;

  localparam int CLK_PERIOD = 10;
  localparam int N = 16;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic advance = 1'b0;
  logic loadEn = 1'b0;
  logic [N-1:0] loadVal = '0;

  logic [N-1:0] stateR, stateT;
  logic wrapR, wrapT, badR, badT;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  token_ring_seq #(.STAGES(N), .MODE(RECOVER_RIPPLE)) dut (
    .clk(clk), .rst(rst), .advance(advance), .loadEn(loadEn), .loadVal(loadVal),
    .stateVec(stateR), .wrapPulse(wrapR), .illegal(badR)
  );

  token_ring_seq #(.STAGES(N), .MODE(RECOVER_RESTART)) dutRestart (
    .clk(clk), .rst(rst), .advance(advance), .loadEn(loadEn), .loadVal(loadVal),
    .stateVec(stateT), .wrapPulse(wrapT), .illegal(badT)
  );

  task automatic check(input bit ok, input string tag, input logic [N-1:0] act, input logic [N-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  function automatic logic [N-1:0] modelRipple(input logic [N-1:0] s);
    return {s[N-2:0], ~|s[N-2:0]};
  endfunction

  function automatic logic [N-1:0] modelRestart(input logic [N-1:0] s);
    if (s[N-1] || s == '0) return N'(1);
    return {s[N-2:0], s[N-1]};
  endfunction

  function automatic bit isLegal(input logic [N-1:0] s);
    return $countones(s) == 1;
  endfunction

  // R1: reset wins over a simultaneous load
  task automatic testReset();
    rst = 1; loadEn = 1; loadVal = '1; advance = 1;
    tick();
    check(stateR == N'(1), "R1 ripple reset", stateR, N'(1));
    check(stateT == N'(1), "R1 restart reset", stateT, N'(1));
    check(!badR && !badT, "R1 reset state legal", {badR, badT}, '0);
    rst = 0; loadEn = 0; advance = 0;
  endtask

  // R2, R4: a full turn of the ring
  task automatic testRotate();
    advance = 1;
    for (int k = 0; k < N + 2; k++) begin
      logic [N-1:0] exp;
      exp = N'(1) << (k % N);
      check(stateR == exp && stateT == exp, "R2 rotate position", stateR, exp);
      check(wrapR == (k % N == N - 1) && wrapT == wrapR, "R4 wrap pulse",
            N'({wrapR, wrapT}), N'({2{k % N == N - 1}}));
      tick();
    end
    advance = 0;
  endtask

  // R8: load beats advance
  task automatic loadVec(input logic [N-1:0] v, input bit adv);
    loadEn = 1; loadVal = v; advance = adv;
    tick();
    loadEn = 0; advance = 0;
    check(stateR == v && stateT == v, "R8 load over advance", stateR, v);
  endtask

  // R9: holding state keeps the flag on the held vector
  task automatic testHold();
    loadVec(16'h0110, 1);
    for (int k = 0; k < 3; k++) begin
      tick();
      check(stateR == 16'h0110 && stateT == 16'h0110, "R9 hold", stateR, 16'h0110);
      check(badR && badT, "R9 flag on held vector", N'({badR, badT}), N'(3));
    end
  endtask

  // R3: flag on chosen patterns, including the two-tier trap vector
  task automatic testPatterns();
    logic [N-1:0] pats [6];
    pats[0] = 16'b1111_1110_1100_0001;
    pats[1] = 16'h0000;
    pats[2] = 16'h8000;
    pats[3] = 16'h0011;
    pats[4] = 16'h1111;
    pats[5] = 16'h0040;
    foreach (pats[i]) begin
      loadVec(pats[i], 0);
      check(badR == !isLegal(pats[i]), "R3 flag pattern", N'(badR), N'(!isLegal(pats[i])));
      check(badT == !isLegal(pats[i]), "R3 flag pattern restart", N'(badT), N'(!isLegal(pats[i])));
    end
  endtask

  // R5: ripple insertion and draining
  task automatic testRipple();
    loadVec('0, 0);
    advance = 1; tick(); advance = 0;
    check(stateR == N'(1), "R5 empty ring refills", stateR, N'(1));
    loadVec(16'h8003, 0);
    advance = 1; tick(); advance = 0;
    check(stateR == 16'h0006, "R5 top token dropped, no insert", stateR, 16'h0006);
    loadVec(16'h8000, 0);
    advance = 1; tick(); advance = 0;
    check(stateR == 16'h0001, "R5 insert after low stages empty", stateR, 16'h0001);
  endtask

  // R6: restart on wrap or empty ring
  task automatic testRestart();
    loadVec(16'h8421, 0);
    advance = 1; tick(); advance = 0;
    check(stateT == N'(1), "R6 restart from terminal", stateT, N'(1));
    loadVec('0, 0);
    advance = 1; tick(); advance = 0;
    check(stateT == N'(1), "R6 restart from empty", stateT, N'(1));
    loadVec(16'h0041, 0);
    advance = 1; tick(); advance = 0;
    check(stateT == 16'h0082, "R6 stray bits rotate", stateT, 16'h0082);
  endtask

  // R7, R3: random corruptions heal within 16 advances
  task automatic testRandomRecovery();
    for (int t = 0; t < 150; t++) begin
      logic [N-1:0] v, mr, mt;
      v = N'($urandom);
      if (t == 0) v = 16'hFFFF;
      if (t == 1) v = 16'h4001;
      loadVec(v, 0);
      mr = v; mt = v;
      advance = 1;
      for (int k = 0; k < N; k++) begin
        tick();
        mr = modelRipple(mr);
        mt = modelRestart(mt);
        check(stateR == mr, "R5 ripple step", stateR, mr);
        check(stateT == mt, "R6 restart step", stateT, mt);
        check(badR == !isLegal(stateR), "R3 flag vs popcount", N'(badR), N'(!isLegal(stateR)));
        check(badT == !isLegal(stateT), "R3 flag vs popcount restart", N'(badT), N'(!isLegal(stateT)));
      end
      advance = 0;
      check(isLegal(stateR), "R7 ripple recovered", stateR, mr);
      check(isLegal(stateT), "R7 restart recovered", stateT, mt);
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    tick();
    testReset();
    testRotate();
    testHold();
    testPatterns();
    testRipple();
    testRestart();
    testRandomRecovery();
    testReset();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule